// File: doc/BRIEF.md
# Burst-of-Four Dual-Port SRAM Core

This block is a synthesizable static memory with a separate read port and a separate write port. Both follow double-data-rate, burst-of-four timing. Double-rate data is modelled on a single internal clock that runs at twice the command rate. Alternate rising edges of that clock stand for the K edge and the K# edge of the command clock, and the `k_edge` output shows which kind of edge comes next. Each command moves exactly four words. Writes take their first data word one command cycle after the write command and then take one word per half cycle. Reads return their first word two command cycles after the read command, with a valid flag that marks the returned words.

Each write word carries its own active-low byte-lane masks. The two ports run at the same time. A read always returns the newest contents of a word, including a write word that is being stored on the same edge the read word leaves the array. A command that arrives while the previous burst of the same kind is still in its two-cycle window is dropped, and a sticky error flag is raised.

Top module: `qburst_sram`

## Requirements
- R1: While `rst` is high, `rd_valid` and `cmd_err` are 0 and `k_edge` is 1.
- R2: `k_edge` alternates on every rising `clk` edge. A value of 1 means the next rising edge is a K edge, and only K edges sample `rd_en` and `wr_en` (both active high).
- R3: A read sampled on K edge E returns its words through the output registers on edges E+4, E+5, E+6 and E+7. `rd_valid` is 1 exactly after those four edges.
- R4: The four words of a burst are at word addresses {addr[AW-1:2], 0} through {addr[AW-1:2], 3}, in rising order. The two low address bits of a command are ignored.
- R5: A write sampled on K edge E captures `wr_data` on edges E+2, E+3, E+4 and E+5, as burst words 0 to 3.
- R6: `wr_bm_n` bit b is captured with each write word. A value of 0 stores bits [9b+8:9b] of that word, and a value of 1 leaves that stored byte unchanged.
- R7: A read and a write can both be accepted on the same K edge, and each completes with its own timing.
- R8: A command of either kind on the K edge two edges after an accepted command of the same kind is ignored, and `cmd_err` becomes 1 and stays 1 until reset. An enable held only on a K# edge is ignored without an error.
- R9: A read word launched on the edge that captures a write word to the same address returns the newly written bytes merged with the unmasked old bytes.
- R10: Commands of one kind spaced two command cycles (four edges) apart are all accepted. Back-to-back reads give an unbroken run of eight valid words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; alternate rising edges are K and K# edges |
| rst | input | 1 | Synchronous active-high reset |
| k_edge | output | 1 | 1 when the next rising edge is a K edge |
| rd_en | input | 1 | Read command, active high, sampled on K edges |
| rd_addr | input | AW | Read word address; the two low bits are ignored |
| wr_en | input | 1 | Write command, active high, sampled on K edges |
| wr_addr | input | AW | Write word address; the two low bits are ignored |
| wr_data | input | DW | Write data word, captured on each write burst edge |
| wr_bm_n | input | DW/9 | Active-low byte masks for the current write word |
| rd_data | output | DW | Read data word |
| rd_valid | output | 1 | 1 while `rd_data` carries a burst word |
| cmd_err | output | 1 | Sticky flag for a command dropped while its port was busy |

## Verification
The two functions that can fall on one edge are the launch of a read word from the array and the capture of a write word into the same word. The bench provokes this by issuing a read of a burst on one K edge and a masked write to the same burst on the next K edge, so that all four write words land on the edges that launch the four read words. The scoreboard applies each write word to its own model at the capture edge and compares each read word with the merged model contents at that edge. The same scoreboard also covers reads and writes accepted together on one K edge, where the two ports touch different bursts.

// File: rtl/qburst_pkg.sv
package qburst_pkg;

    // Words moved per command and the address bits that index them.
    localparam int BEATS  = 4;
    localparam int BEAT_W = 2;

    // Width of one maskable byte lane.
    localparam int LANE_W = 9;

    // Command-to-data distance in command-clock cycles.
    localparam int READ_LAT_CYC  = 2;
    localparam int WRITE_LAT_CYC = 1;

    typedef enum logic {
        PORT_RD = 1'b0,
        PORT_WR = 1'b1
    } port_e;

    // Number of double-rate edges from command sampling to the first word.
    function automatic int lead_edges(port_e kind);
        return (kind == PORT_RD) ? 2 * READ_LAT_CYC : 2 * WRITE_LAT_CYC;
    endfunction

endpackage

// File: rtl/qburst_seq.sv
module qburst_seq
    import qburst_pkg::*;
#(
    parameter port_e KIND = PORT_RD,
    parameter int    AW   = 8,
    localparam int   LEAD = lead_edges(KIND),
    localparam int   BW   = AW - BEAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [BW-1:0] cmd_blk,
    output logic          busy,
    output logic          beat_on,
    output logic [AW-1:0] beat_addr
);

    typedef struct packed {
        logic          v;
        logic [BW-1:0] blk;
    } slot_t;

    slot_t             pipe [LEAD];
    logic              act;
    logic [BW-1:0]     cur_blk;
    logic [BEAT_W-1:0] idx;

    generate
        if (LEAD < 2) begin : g_bad_lead
            initial $error("qburst_seq needs a lead of at least two edges");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LEAD; k++) pipe[k] <= '0;
            act     <= 1'b0;
            cur_blk <= '0;
            idx     <= '0;
        end else begin
            pipe[0] <= slot_t'{v: go, blk: cmd_blk};
            for (int k = 1; k < LEAD; k++) pipe[k] <= pipe[k-1];
            if (pipe[LEAD-1].v) begin
                act     <= 1'b1;
                cur_blk <= pipe[LEAD-1].blk;
                idx     <= BEAT_W'(1);
            end else if (act) begin
                idx <= idx + 1'b1;
                if (idx == BEAT_W'(BEATS - 1)) act <= 1'b0;
            end
        end
    end

    // An accepted command sits in tap 1 on the following K edge: that edge
    // falls inside the two-cycle window of the accepted burst.
    assign busy      = pipe[1].v;
    assign beat_on   = pipe[LEAD-1].v | act;
    assign beat_addr = pipe[LEAD-1].v ? {pipe[LEAD-1].blk, BEAT_W'(0)}
                                      : {cur_blk, idx};

endmodule

// File: rtl/qburst_mem.sv
module qburst_mem
    import qburst_pkg::*;
#(
    parameter int  AW    = 8,
    parameter int  DW    = 36,
    localparam int LANES = DW / LANE_W,
    localparam int WORDS = 1 << AW
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] wmask_n,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);

    logic hit;
    assign hit = we && (waddr == raddr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [WORDS];
        logic              lane_we;

        assign lane_we = we & ~wmask_n[g];

        always_ff @(posedge clk) begin
            if (lane_we) store[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        // A write of this lane on the same edge wins over the stored byte.
        assign rdata[g*LANE_W +: LANE_W] = (hit && !wmask_n[g])
                                         ? wdata[g*LANE_W +: LANE_W]
                                         : store[raddr];
    end

endmodule

// File: rtl/qburst_sram.sv
module qburst_sram
    import qburst_pkg::*;
#(
    parameter int  DW    = 36,
    parameter int  DEPTH = 64,
    localparam int AW    = $clog2(DEPTH) + BEAT_W,
    localparam int LANES = DW / LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    output logic             k_edge,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [LANES-1:0] wr_bm_n,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             cmd_err
);

    logic          ph;
    logic          rd_go, wr_go;
    logic          rd_busy, wr_busy;
    logic          rd_on, wr_on;
    logic [AW-1:0] rd_word, wr_word;
    logic [DW-1:0] arr_q;
    logic          unused_low_bits;

    // Edge phase: 0 means the coming rising edge is a K edge.
    always_ff @(posedge clk) begin
        if (rst) ph <= 1'b0;
        else     ph <= ~ph;
    end

    assign k_edge = ~ph;
    assign rd_go  = rd_en & k_edge & ~rd_busy;
    assign wr_go  = wr_en & k_edge & ~wr_busy;
    assign unused_low_bits = ^{rd_addr[BEAT_W-1:0], wr_addr[BEAT_W-1:0]};

    qburst_seq #(.KIND(PORT_RD), .AW(AW)) u_rd_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (rd_go),
        .cmd_blk  (rd_addr[AW-1:BEAT_W]),
        .busy     (rd_busy),
        .beat_on  (rd_on),
        .beat_addr(rd_word)
    );

    qburst_seq #(.KIND(PORT_WR), .AW(AW)) u_wr_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (wr_go),
        .cmd_blk  (wr_addr[AW-1:BEAT_W]),
        .busy     (wr_busy),
        .beat_on  (wr_on),
        .beat_addr(wr_word)
    );

    qburst_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk    (clk),
        .we     (wr_on),
        .waddr  (wr_word),
        .wdata  (wr_data),
        .wmask_n(wr_bm_n),
        .raddr  (rd_word),
        .rdata  (arr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            cmd_err  <= 1'b0;
        end else begin
            rd_data  <= rd_on ? arr_q : '0;
            rd_valid <= rd_on;
            if (k_edge && ((rd_en && rd_busy) || (wr_en && wr_busy)))
                cmd_err <= 1'b1;
        end
    end

endmodule

// File: rtl/qburst_chk.sv
module qburst_chk (
    input logic clk,
    input logic rst,
    input logic k_edge,
    input logic rd_en,
    input logic wr_en,
    input logic rd_go,
    input logic wr_go,
    input logic rd_busy,
    input logic wr_busy,
    input logic wr_on,
    input logic rd_valid,
    input logic cmd_err
);

    logic [1:0] vrun;

    always_ff @(posedge clk) begin
        if (rst)           vrun <= '0;
        else if (rd_valid) vrun <= vrun + 1'b1;
        else               vrun <= '0;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!rd_valid && !cmd_err && k_edge));

    assert_phase_alt_R2: assert property (@(posedge clk) disable iff (rst)
        k_edge |=> !k_edge);

    assert_phase_back_R2: assert property (@(posedge clk) disable iff (rst)
        !k_edge |=> k_edge);

    assert_read_latency_R3: assert property (@(posedge clk) disable iff (rst)
        rd_go |-> ##5 rd_valid);

    assert_valid_run_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_valid) |-> (vrun == 2'd0));

    assert_write_capture_R5: assert property (@(posedge clk) disable iff (rst)
        wr_go |-> ##2 wr_on);

    assert_rd_busy_err_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && k_edge && rd_busy) |=> cmd_err);

    assert_wr_busy_err_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && k_edge && wr_busy) |=> cmd_err);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_err |=> cmd_err);

endmodule

bind qburst_sram qburst_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .k_edge  (k_edge),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .rd_go   (rd_go),
    .wr_go   (wr_go),
    .rd_busy (rd_busy),
    .wr_busy (wr_busy),
    .wr_on   (wr_on),
    .rd_valid(rd_valid),
    .cmd_err (cmd_err)
);

// File: tb/sim_qburst_sram.sv
`timescale 1ns/1ps
module sim_qburst_sram;

    localparam int DW    = 36;
    localparam int DEPTH = 64;
    localparam int AW    = 8;
    localparam int LN    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          k_edge;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [LN-1:0] wr_bm_n = '1;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          cmd_err;

    always #2 clk = ~clk;

    qburst_sram #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .k_edge(k_edge),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_bm_n(wr_bm_n),
        .rd_data(rd_data), .rd_valid(rd_valid), .cmd_err(cmd_err)
    );

    typedef struct {
        int    cyc;
        int    addr;
        string tag;
    } exp_t;

    int            cyc = 0;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;
    int            last_rd = -100;
    int            last_wr = -100;
    logic [DW-1:0] model [1 << AW];
    exp_t          q [$];
    exp_t          mon_e;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [4*DW-1:0] bundle(input int s);
        logic [4*DW-1:0] b;
        for (int i = 0; i < 4; i++)
            b[i*DW +: DW] = {4'(s + i), 32'((s * 4 + i) * 32'h9E3779B1)};
        return b;
    endfunction

    // Scoreboard monitor: each valid word is matched against the queue.
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R3,R8", "unexpected valid word", 64'(rd_data), 0);
                end else begin
                    mon_e = q.pop_front();
                    chk(mon_e.cyc == cyc, mon_e.tag, "word edge", 64'(cyc), 64'(mon_e.cyc));
                    chk(rd_data == model[mon_e.addr], mon_e.tag, "word data",
                        64'(rd_data), 64'(model[mon_e.addr]));
                end
            end else if (q.size() != 0 && q[0].cyc <= cyc) begin
                mon_e = q.pop_front();
                chk(1'b0, mon_e.tag, "missing word", 64'(cyc), 64'(mon_e.cyc));
            end
        end
    end

    task automatic wait_k();
        @(negedge clk);
        while (!k_edge) @(negedge clk);
    endtask

    // Drives the four write words; the model follows at each capture edge.
    task automatic wbeats(input bit acc, input int base,
                          input logic [4*DW-1:0] dat, input logic [4*LN-1:0] msk);
        logic [DW-1:0] d;
        logic [LN-1:0] m;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            d = dat[i*DW +: DW];
            m = msk[i*LN +: LN];
            wr_data = d;
            wr_bm_n = m;
            @(posedge clk);
            if (acc)
                for (int b = 0; b < LN; b++)
                    if (!m[b]) model[base + i][b*9 +: 9] = d[b*9 +: 9];
            if (i < 3) @(negedge clk);
        end
    endtask

    // Driver: issues commands on the next K edge and pushes expected words.
    task automatic issue(input bit do_rd, input int ra, input bit do_wr, input int wa,
                         input logic [4*DW-1:0] dat, input logic [4*LN-1:0] msk,
                         input string tag);
        int t;
        bit racc, wacc;
        wait_k();
        t = cyc + 1;
        rd_en   = do_rd;
        rd_addr = AW'(ra);
        wr_en   = do_wr;
        wr_addr = AW'(wa);
        racc = do_rd && (t - last_rd >= 4);
        wacc = do_wr && (t - last_wr >= 4);
        if (racc) begin
            last_rd = t;
            for (int i = 0; i < 4; i++)
                q.push_back('{t + 4 + i, (ra & ~3) + i, tag});
        end
        if (wacc) last_wr = t;
        if (do_wr) begin
            fork
                wbeats(wacc, wa & ~3, dat, msk);
            join_none
        end
        @(negedge clk);
        rd_en = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        bit prev;
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        idle(3);
        // R1: reset state
        chk(rd_valid == 1'b0, "R1", "rd_valid in reset", 64'(rd_valid), 0);
        chk(cmd_err == 1'b0, "R1", "cmd_err in reset", 64'(cmd_err), 0);
        chk(k_edge == 1'b1, "R1", "k_edge in reset", 64'(k_edge), 1);
        rst = 1'b0;
        // R2: edge phase alternates
        prev = k_edge;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(k_edge != prev, "R2", "k_edge toggle", 64'(k_edge), 64'(!prev));
            prev = k_edge;
        end

        // R5 and R4: full write with nonzero low address bits, then read back
        issue(0, 0, 1, 3 * 4 + 2, bundle(1), 16'h0000, "R5");
        idle(6);
        issue(1, 3 * 4 + 1, 0, 0, '0, '1, "R3,R4,R5");
        idle(10);

        // R6: different byte masks per word
        issue(0, 0, 1, 3 * 4, bundle(9), 16'hCA35, "R6");
        idle(6);
        issue(1, 3 * 4, 0, 0, '0, '1, "R6");
        idle(10);

        // R7: read and write accepted on the same K edge
        issue(1, 3 * 4, 1, 7 * 4, bundle(17), 16'h0000, "R7");
        idle(8);
        issue(1, 7 * 4 + 3, 0, 0, '0, '1, "R7");
        idle(10);

        // R10: reads and writes spaced two command cycles apart
        issue(0, 0, 1, 10 * 4, bundle(25), 16'h0000, "R10");
        @(negedge clk);
        issue(0, 0, 1, 11 * 4, bundle(33), 16'h0000, "R10");
        idle(8);
        issue(1, 10 * 4, 0, 0, '0, '1, "R10");
        @(negedge clk);
        issue(1, 11 * 4, 0, 0, '0, '1, "R10");
        @(negedge clk);
        issue(1, 7 * 4, 0, 0, '0, '1, "R10");
        idle(14);

        // R9: read launches on the same edges that capture a masked write
        issue(0, 0, 1, 20 * 4, bundle(41), 16'h0000, "R9");
        idle(8);
        issue(1, 20 * 4, 0, 0, '0, '1, "R9");
        issue(0, 0, 1, 20 * 4, bundle(49), 16'h5A3C, "R9");
        idle(12);

        // R8: enables held only on a K# edge have no effect
        wait_k();
        @(negedge clk);
        rd_en = 1'b1;
        wr_en = 1'b1;
        wr_addr = AW'(7 * 4);
        wr_data = '1;
        wr_bm_n = '0;
        @(negedge clk);
        rd_en = 1'b0;
        wr_en = 1'b0;
        idle(12);
        chk(cmd_err == 1'b0, "R8", "cmd_err after K# enable", 64'(cmd_err), 0);
        issue(1, 7 * 4, 0, 0, '0, '1, "R8");
        idle(12);

        // R8: second read one command cycle after an accepted read
        issue(1, 3 * 4, 0, 0, '0, '1, "R8");
        issue(1, 10 * 4, 0, 0, '0, '1, "R8");
        chk(cmd_err == 1'b1, "R8", "cmd_err after busy read", 64'(cmd_err), 1);
        idle(12);
        // R8: second write is dropped and leaves the stored data alone
        issue(0, 0, 1, 30 * 4, bundle(57), 16'h0000, "R8");
        issue(0, 0, 1, 30 * 4, bundle(65), 16'h0000, "R8");
        idle(8);
        issue(1, 30 * 4, 0, 0, '0, '1, "R8");
        idle(14);
        chk(cmd_err == 1'b1, "R8", "cmd_err sticky", 64'(cmd_err), 1);
        chk(q.size() == 0, "R3", "pending words", 64'(q.size()), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule